// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block drives the mode-setting part of DDR2 SDRAM bring-up over a simple command/address interface: a 3-bit command code, a 2-bit bank select and a row-address word.

A single start pulse launches a fixed run of eight commands:
1. enable the DLL through extended mode register 1;
2. load the mode register with DLL reset set;
3. precharge all banks;
4. auto-refresh, twice;
5. reload the mode register with DLL reset cleared;
6. set the OCD field to its calibration default;
7. clear the OCD field to leave calibration.

Between commands the sequencer holds the command lines at NOP for a programmed number of cycles. Each gap depends on the command just issued:
- mode-register commands use `T_MRD`;
- precharge uses `T_RP`;
- refresh uses `T_RFC`;
- the DLL enable uses a longer `T_DLL`, which gives the DLL time to lock.

CAS latency and burst length come from input ports and are captured on the start cycle. After the last gap a done flag rises and stays high until reset. A step index reports which command was issued most recently.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset `cmd_o` is NOP (code 0), `done_o` is 0 and `step_o` is 0.
- R2: A start pulse produces exactly eight commands, with codes in this order: 5, 3, 2, 4, 4, 3, 5, 5. The codes are 5 for extended mode register, 3 for mode register, 2 for precharge-all and 4 for auto-refresh.
- R3: Every extended-mode-register command drives `ba_o` = 2'b01, and every mode-register command drives `ba_o` = 2'b00.
- R4: The first mode-register command sets address bit 8 (DLL reset) and the second clears it. Both carry CAS latency in bits 6:4 and burst length in bits 2:0, as sampled in the start cycle. All other address bits are 0.
- R5: In the first extended command the address word is all zeros, so bit 0 = 0 and the DLL is enabled. In the second extended command bits 9:7 = 3'b111 (OCD default) and all other bits are 0. In the third extended command the address word is all zeros (OCD exit).
- R6: The precharge-all command drives address bit 10 high and all other address bits low.
- R7: The gap from the issue of one command to the next equals the gap of the command just issued:
  - `T_DLL` after the DLL enable;
  - `T_MRD` after any other mode-register command;
  - `T_RP` after precharge;
  - `T_RFC` after each refresh.
- R8: Each command is present for exactly one cycle, and `cmd_o` shows NOP in every other cycle.
- R9: `done_o` rises `T_MRD` cycles after the last command and stays high until reset.
- R10: A start pulse while the sequence runs, or after it has finished, has no effect. No command is issued, `step_o` is unchanged and the captured CAS latency and burst length are kept.
- R11: `step_o` equals the position, counting from 0, of the most recently issued command in the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; acted on only while idle |
| cas_lat_i | input | 3 | CAS latency field, sampled at start |
| burst_len_i | input | 3 | Burst length field, sampled at start |
| cmd_o | output | 3 | Command code (0 = NOP) |
| ba_o | output | 2 | Bank address |
| addr_o | output | ROW_W | Row address / mode register contents |
| step_o | output | 3 | Index of the last issued command |
| done_o | output | 1 | Sequence finished (sticky) |

## Verification
The first command is registered on the edge that samples `start_i`, so it is due one cycle after the start pulse. Each later command is due exactly the gap of the command before it. `done_o` is due `T_MRD` cycles after the last command.

A driver task computes each expected command and the spacing that must precede it, and pushes them into a queue. A monitor samples on the falling clock edge and pops one entry whenever a non-NOP command appears. It compares the measured cycle distance from the previous command with the expected spacing, so any early, late or extra command shows up as a miscompare. Start pulses injected mid-run and after completion must leave the command stream and `step_o` untouched.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PALL = 3'd2,
    CMD_LMR  = 3'd3,
    CMD_REF  = 3'd4,
    CMD_EMR  = 3'd5
  } cmd_e;

  localparam int unsigned NUM_STEPS = 8;
  localparam logic [2:0]  LAST_STEP = 3'(NUM_STEPS - 1);

  // mode word bit positions
  localparam int unsigned DLL_RST_BIT = 8;
  localparam int unsigned PALL_BIT    = 10;
  localparam int unsigned OCD_LSB     = 7;
  localparam int unsigned CL_LSB      = 4;
  localparam int unsigned BL_LSB      = 0;
endpackage

// File: rtl/ddr2_init_step_rom.sv
module ddr2_init_step_rom
  import ddr2_init_pkg::*;
#(
  parameter int unsigned ROW_W = 14,
  parameter int unsigned T_MRD = 2,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_RFC = 8,
  parameter int unsigned T_DLL = 200,
  parameter int unsigned CW    = 8
) (
  input  logic [2:0]       step_i,
  input  logic [2:0]       cas_lat_i,
  input  logic [2:0]       burst_len_i,
  output cmd_e             cmd_o,
  output logic [1:0]       ba_o,
  output logic [ROW_W-1:0] addr_o,
  output logic [CW-1:0]    gap_o
);
  logic [ROW_W-1:0] mode_w;

  always_comb begin
    mode_w = '0;
    mode_w[CL_LSB +: 3] = cas_lat_i;
    mode_w[BL_LSB +: 3] = burst_len_i;
  end

  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = 2'b00;
    addr_o = '0;
    gap_o  = CW'(T_MRD);
    unique case (step_i)
      3'd0: begin cmd_o = CMD_EMR; ba_o = 2'b01; gap_o = CW'(T_DLL); end
      3'd1: begin
        cmd_o = CMD_LMR; addr_o = mode_w; addr_o[DLL_RST_BIT] = 1'b1;
      end
      3'd2: begin cmd_o = CMD_PALL; addr_o[PALL_BIT] = 1'b1; gap_o = CW'(T_RP); end
      3'd3, 3'd4: begin cmd_o = CMD_REF; gap_o = CW'(T_RFC); end
      3'd5: begin cmd_o = CMD_LMR; addr_o = mode_w; end
      3'd6: begin cmd_o = CMD_EMR; ba_o = 2'b01; addr_o[OCD_LSB +: 3] = 3'b111; end
      default: begin cmd_o = CMD_EMR; ba_o = 2'b01; end
    endcase
  end
endmodule

// File: rtl/ddr2_init_gap_cnt.sv
module ddr2_init_gap_cnt #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] gap_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= gap_i - CW'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign zero_o = (cnt_q == '0);

  // R7
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int unsigned ROW_W = 14,
  parameter int unsigned T_MRD = 2,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_RFC = 8,
  parameter int unsigned T_DLL = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       cas_lat_i,
  input  logic [2:0]       burst_len_i,
  output logic [2:0]       cmd_o,
  output logic [1:0]       ba_o,
  output logic [ROW_W-1:0] addr_o,
  output logic [2:0]       step_o,
  output logic             done_o
);
  localparam int unsigned M1      = (T_MRD > T_RP) ? T_MRD : T_RP;
  localparam int unsigned M2      = (T_RFC > T_DLL) ? T_RFC : T_DLL;
  localparam int unsigned GAP_MAX = (M1 > M2) ? M1 : M2;
  localparam int unsigned CW      = $clog2(GAP_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_e;

  state_e           st_q;
  logic [2:0]       step_q, nxt_step;
  logic [2:0]       cl_q, bl_q, cl_sel, bl_sel;
  cmd_e             rom_cmd;
  logic [1:0]       rom_ba;
  logic [ROW_W-1:0] rom_addr;
  logic [CW-1:0]    rom_gap;
  logic             gap_zero, issue, finish;

  assign issue  = (st_q == S_IDLE && start_i) ||
                  (st_q == S_RUN && gap_zero && step_q != LAST_STEP);
  assign finish = (st_q == S_RUN) && gap_zero && (step_q == LAST_STEP);
  assign nxt_step = (st_q == S_IDLE) ? 3'd0 : step_q + 3'd1;
  assign cl_sel   = (st_q == S_IDLE) ? cas_lat_i   : cl_q;
  assign bl_sel   = (st_q == S_IDLE) ? burst_len_i : bl_q;

  ddr2_init_step_rom #(
    .ROW_W(ROW_W), .T_MRD(T_MRD), .T_RP(T_RP), .T_RFC(T_RFC),
    .T_DLL(T_DLL), .CW(CW)
  ) u_rom (
    .step_i     (nxt_step),
    .cas_lat_i  (cl_sel),
    .burst_len_i(bl_sel),
    .cmd_o      (rom_cmd),
    .ba_o       (rom_ba),
    .addr_o     (rom_addr),
    .gap_o      (rom_gap)
  );

  ddr2_init_gap_cnt #(.CW(CW)) u_gap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(issue),
    .gap_i (rom_gap),
    .zero_o(gap_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      step_q <= '0;
      cl_q   <= '0;
      bl_q   <= '0;
      cmd_o  <= CMD_NOP;
      ba_o   <= '0;
      addr_o <= '0;
      done_o <= 1'b0;
    end else begin
      cmd_o <= CMD_NOP;
      if (st_q == S_IDLE && start_i) begin
        cl_q <= cas_lat_i;
        bl_q <= burst_len_i;
      end
      if (issue) begin
        st_q   <= S_RUN;
        step_q <= nxt_step;
        cmd_o  <= rom_cmd;
        ba_o   <= rom_ba;
        addr_o <= rom_addr;
      end else if (finish) begin
        st_q   <= S_DONE;
        done_o <= 1'b1;
      end
    end
  end

  assign step_o = step_q;

  // R3
  emr_ba_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_EMR) |-> (ba_o == 2'b01));
  // R3
  lmr_ba_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_LMR) |-> (ba_o == 2'b00));
  // R2
  ref_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REF) |-> (step_o == 3'd3 || step_o == 3'd4));
  // R9
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  // R9
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cmd_o == CMD_NOP && step_o == LAST_STEP));
  // R10
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != S_IDLE && start_i) |=> ($stable(cl_q) && $stable(bl_q)));
  // R8
  one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != CMD_NOP && T_MRD > 1 && T_RP > 1 && T_RFC > 1) |=> (cmd_o == CMD_NOP));
endmodule

// File: tb/ddr2_init_seq_bench.sv
module ddr2_init_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 14;
  localparam int T_MRD = 2;
  localparam int T_RP  = 3;
  localparam int T_RFC = 8;
  localparam int T_DLL = 200;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [2:0]       cas_lat = '0, burst_len = '0;
  logic [2:0]       cmd;
  logic [1:0]       ba;
  logic [ROW_W-1:0] addr;
  logic [2:0]       step;
  logic             done;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr2_init_seq #(.ROW_W(ROW_W), .T_MRD(T_MRD), .T_RP(T_RP), .T_RFC(T_RFC), .T_DLL(T_DLL))
  u_ddr2_init_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cas_lat_i(cas_lat),
    .burst_len_i(burst_len), .cmd_o(cmd), .ba_o(ba), .addr_o(addr),
    .step_o(step), .done_o(done)
  );

  typedef struct {
    logic [2:0]       cmd;
    logic [1:0]       ba;
    logic [ROW_W-1:0] addr;
    logic [2:0]       step;
    int               gap;   // expected distance from previous command, -1 = none
    string            req;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_err = 0;
  int cyc = 0, last_cyc = 0;
  logic done_prev = 1'b0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      done_prev = 1'b0;
    end else begin
      if (cmd != 3'd0) begin
        if (q.size() == 0) begin
          check(1'b0, "R10", "unexpected command", int'(cmd), 0);
        end else begin
          item_t it;
          it = q.pop_front();
          check(cmd == it.cmd, "R2", "cmd", int'(cmd), int'(it.cmd));
          check(ba == it.ba, "R3", "bank", int'(ba), int'(it.ba));
          check(addr == it.addr, it.req, "addr", int'(addr), int'(it.addr));
          check(step == it.step, "R11", "step", int'(step), int'(it.step));
          if (it.gap >= 0)
            check(cyc - last_cyc == it.gap, "R7", "gap", cyc - last_cyc, it.gap);
        end
        last_cyc = cyc;
      end
      if (done && !done_prev) begin
        check(cyc - last_cyc == T_MRD, "R9", "done delay", cyc - last_cyc, T_MRD);
        check(q.size() == 0, "R2", "commands pending at done", q.size(), 0);
      end
      done_prev = done;
    end
  end

  function automatic logic [ROW_W-1:0] mode_word(input logic [2:0] cl, input logic [2:0] bl,
                                                 input bit dll_rst);
    logic [ROW_W-1:0] w = '0;
    w[6:4] = cl;
    w[2:0] = bl;
    w[8]   = dll_rst;
    return w;
  endfunction

  task automatic push(input logic [2:0] c, input logic [1:0] b, input logic [ROW_W-1:0] a,
                      input logic [2:0] s, input int g, input string r);
    item_t it;
    it.cmd = c; it.ba = b; it.addr = a; it.step = s; it.gap = g; it.req = r;
    q.push_back(it);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check(cmd == 3'd0, "R1", "reset cmd", int'(cmd), 0);
    check(done == 1'b0, "R1", "reset done", int'(done), 0);
    check(step == 3'd0, "R1", "reset step", int'(step), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_seq(input logic [2:0] cl, input logic [2:0] bl, input bit poke);
    logic [ROW_W-1:0] ocd_def;
    ocd_def = '0;
    ocd_def[9:7] = 3'b111;
    push(3'd5, 2'b01, '0,                    3'd0, -1,    "R5");
    push(3'd3, 2'b00, mode_word(cl, bl, 1),  3'd1, T_DLL, "R4");
    push(3'd2, 2'b00, ROW_W'(1) << 10,       3'd2, T_MRD, "R6");
    push(3'd4, 2'b00, '0,                    3'd3, T_RP,  "R2");
    push(3'd4, 2'b00, '0,                    3'd4, T_RFC, "R2");
    push(3'd3, 2'b00, mode_word(cl, bl, 0),  3'd5, T_RFC, "R4");
    push(3'd5, 2'b01, ocd_def,               3'd6, T_MRD, "R5");
    push(3'd5, 2'b01, '0,                    3'd7, T_MRD, "R5");
    cas_lat = cl;
    burst_len = bl;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (30) @(negedge clk);
      // R10: restart attempt mid-run with different fields
      cas_lat = ~cl;
      burst_len = ~bl;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    check(done == 1'b1, "R9", "done reached", int'(done), 1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    do_reset();
    run_seq(3'd4, 3'd2, 1'b1);
    // R10: start after done
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    check(done == 1'b1, "R9", "done sticky", int'(done), 1);
    check(step == 3'd7, "R10", "step after late start", int'(step), 7);
    do_reset();
    run_seq(3'd3, 3'd3, 1'b0);
    do_reset();
    run_seq(3'd6, 3'd5, 1'b1);
    check(q.size() == 0, "R2", "leftover items", q.size(), 0);
    finish_run();
  end
endmodule